// File: doc/BRIEF.md
# Rotate-and-Mask Word Execution Unit

This integer execution unit handles two 32-bit rotate operations for a core with 64-bit registers. It accepts a decoded 32-bit instruction word and three operands: the source value, the previous destination value and a shift operand. The low word of the source is rotated left and copied into both halves of a 64-bit word. The copy is then combined with a mask that the instruction's begin and end indices produce. In rotate-AND mode the rotate count comes from the shift operand and the masked value is the result. In insert mode the count is an immediate in the instruction, and the masked value overwrites only the masked bits of the previous destination value.

Instructions enter through a valid/ready handshake and leave through one output register, one cycle after acceptance. When the record bit is set, a 4-bit condition field comes out with the result. Any opcode other than the two supported ones gives a one-beat illegal-operation indication and no result.

Top module: `rotmask_unit`

## Requirements
- R1: After reset, `outValid`, `illegalOp`, `resWrite` and `condWrite` are 0 and `inReady` is 1.
- R2: Opcode 23 in `instrWord[31:26]` selects rotate-AND mode. The result is the low word of `srcVal` rotated left by `shiftVal[4:0]`, copied into both 32-bit halves, then ANDed with the mask.
- R3: Opcode 20 selects insert mode. The rotate count is `instrWord[15:11]` and the result is `(rot & mask) | (dstVal & ~mask)`.
- R4: The begin index is `instrWord[10:6]` and the end index is `instrWord[5:1]`. Counting the 64-bit word from bit 0 at its MSB, when begin <= end the mask is one from position begin+32 through end+32 and zero elsewhere, so the upper 32 result bits are zero.
- R5: When begin > end the mask wraps. It is zero only at positions strictly between end+32 and begin+32, so the upper 32 mask bits are all one.
- R6: In rotate-AND mode with begin 0 and end 31, the low 32 result bits are a plain left rotate of the source low word and the upper 32 bits are zero.
- R7: When record bit `instrWord[0]` is 1 on a legal op, `condWrite` is 1 and `condVal` = {LT, GT, EQ, SO}, bits 3 down to 0. LT, GT and EQ come from a signed compare of the 64-bit result with zero, and SO copies `sumOvf`. When the record bit is 0, `condWrite` is 0 and `condVal` is 0.
- R8: Any other opcode gives `illegalOp`=1, `resWrite`=0, `condWrite`=0 and `resultVal`=0 for that output beat only. `resWrite` is 1 on every legal beat.
- R9: An instruction accepted on a clock edge (`inValid` and `inReady` both 1) appears with `outValid`=1 right after that edge. `inReady` is 1 when the output register is empty or being drained.
- R10: While `outValid`=1 and `outReady`=0, all outputs hold their values and `inReady` is 0, so no new instruction is taken.
- R11: Only `shiftVal[4:0]` affects rotate-AND mode, and `shiftVal` has no effect in insert mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands are presented |
| inReady | output | 1 | Unit can take an instruction this cycle |
| instrWord | input | 32 | Decoded instruction word, opcode in bits 31:26 |
| srcVal | input | 64 | Source operand; its low word is rotated |
| dstVal | input | 64 | Previous destination value used by insert mode |
| shiftVal | input | 64 | Shift operand; low five bits are the rotate-AND count |
| sumOvf | input | 1 | Summary-overflow flag copied into the condition field |
| outValid | output | 1 | Output register holds a beat |
| outReady | input | 1 | Consumer takes the beat |
| resultVal | output | 64 | Computed result |
| resWrite | output | 1 | Result should be written back |
| condWrite | output | 1 | Condition field should be written |
| condVal | output | 4 | Condition field {LT, GT, EQ, SO} |
| illegalOp | output | 1 | Unsupported opcode was issued |

## Verification
The interaction to cover is a stalled output register meeting a new instruction in the same cycle. The held result must stay put while the next instruction waits, and must then be replaced on the very edge where the consumer drains it. The bench holds `outReady` low for several cycles while a second instruction is kept valid. It checks that the first result, its condition field and `inReady`=0 stay unchanged. It then raises `outReady` and checks that the second result appears exactly one edge later, with no empty beat between the two.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  typedef struct packed {
    logic [5:0] opc;
    logic [4:0] rsIdx;
    logic [4:0] raIdx;
    logic [4:0] rbSh;
    logic [4:0] maskBeg;
    logic [4:0] maskEnd;
    logic       recBit;
  } instrFields_t;

  typedef struct packed {
    logic load;
    logic selInsert;
    logic legal;
    logic recCond;
  } dpStrobe_t;

endpackage

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int HALF_W = 32,
  parameter int IDX_W  = $clog2(HALF_W)
) (
  input  logic [IDX_W-1:0]    maskBeg,
  input  logic [IDX_W-1:0]    maskEnd,
  output logic [2*HALF_W-1:0] maskVal
);
  logic wrapMask;
  logic [HALF_W-1:0] lowMask;

  assign wrapMask = maskBeg > maskEnd;

  // Bit j of the low word sits at MSB-first position HALF_W-1-j.
  for (genvar j = 0; j < HALF_W; j++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(HALF_W - 1 - j);
    logic geBeg;
    logic leEnd;
    assign geBeg = POS >= maskBeg;
    assign leEnd = POS <= maskEnd;
    assign lowMask[j] = wrapMask ? (geBeg | leEnd) : (geBeg & leEnd);
  end

  assign maskVal = {{HALF_W{wrapMask}}, lowMask};
endmodule

// File: rtl/rotmask_ctrl.sv
module rotmask_ctrl
  import rotmask_pkg::*;
#(
  parameter logic [5:0] OPC_ROTAND = 6'd23,
  parameter logic [5:0] OPC_INSERT = 6'd20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       outReady,
  input  logic [5:0] opc,
  input  logic       recBit,
  output logic       inReady,
  output logic       outValid,
  output logic       illegalOp,
  output logic       resWrite,
  output logic       condWrite,
  output dpStrobe_t  strobe
);
  logic accept;
  logic isRot;
  logic isIns;
  logic legalOp;

  assign isRot   = opc == OPC_ROTAND;
  assign isIns   = opc == OPC_INSERT;
  assign legalOp = isRot | isIns;
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.load      = accept;
    strobe.selInsert = isIns;
    strobe.legal     = legalOp;
    strobe.recCond   = recBit && legalOp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
      resWrite  <= 1'b0;
      condWrite <= 1'b0;
    end else if (accept) begin
      outValid  <= 1'b1;
      illegalOp <= !legalOp;
      resWrite  <= legalOp;
      condWrite <= recBit && legalOp;
    end else if (outReady) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
      resWrite  <= 1'b0;
      condWrite <= 1'b0;
    end
  end
endmodule

// File: rtl/rotmask_dp.sv
module rotmask_dp
  import rotmask_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int HALF_W = XLEN / 2,
  parameter int IDX_W  = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  shImm,
  input  logic [IDX_W-1:0]  shReg,
  input  logic [IDX_W-1:0]  maskBeg,
  input  logic [IDX_W-1:0]  maskEnd,
  input  logic [HALF_W-1:0] srcLow,
  input  logic [XLEN-1:0]   dstVal,
  input  logic              sumOvf,
  output logic [XLEN-1:0]   resultVal,
  output logic [3:0]        condVal
);
  logic [IDX_W-1:0]  rotCount;
  logic [XLEN-1:0]   dblShift;
  logic [HALF_W-1:0] rotWord;
  logic [XLEN-1:0]   replWord;
  logic [XLEN-1:0]   maskVal;
  logic [XLEN-1:0]   andPart;
  logic [XLEN-1:0]   nextRes;
  logic              isNeg;
  logic              isZero;
  logic [3:0]        nextCond;

  rotmask_maskgen #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_maskgen (
    .maskBeg (maskBeg),
    .maskEnd (maskEnd),
    .maskVal (maskVal)
  );

  assign rotCount = strobe.selInsert ? shImm : shReg;
  assign dblShift = {srcLow, srcLow} << rotCount;
  assign rotWord  = dblShift[XLEN-1:HALF_W];
  assign replWord = {rotWord, rotWord};
  assign andPart  = replWord & maskVal;
  assign nextRes  = strobe.selInsert ? (andPart | (dstVal & ~maskVal)) : andPart;

  assign isNeg    = nextRes[XLEN-1];
  assign isZero   = nextRes == '0;
  assign nextCond = {isNeg, !isNeg && !isZero, isZero, sumOvf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultVal <= '0;
      condVal   <= '0;
    end else if (strobe.load) begin
      resultVal <= strobe.legal ? nextRes : '0;
      condVal   <= strobe.recCond ? nextCond : 4'b0000;
    end
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int XLEN = 64,
  parameter logic [5:0] OPC_ROTAND = 6'd23,
  parameter logic [5:0] OPC_INSERT = 6'd20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  output logic            inReady,
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN-1:0] dstVal,
  input  logic [XLEN-1:0] shiftVal,
  input  logic            sumOvf,
  output logic            outValid,
  input  logic            outReady,
  output logic [XLEN-1:0] resultVal,
  output logic            resWrite,
  output logic            condWrite,
  output logic [3:0]      condVal,
  output logic            illegalOp
);
  localparam int HALF_W = XLEN / 2;
  localparam int IDX_W  = $clog2(HALF_W);

  instrFields_t fields;
  dpStrobe_t    strobe;
  logic         unusedBits;

  assign fields     = instrFields_t'(instrWord);
  assign unusedBits = ^{fields.rsIdx, fields.raIdx, srcVal[XLEN-1:HALF_W], shiftVal[XLEN-1:IDX_W]};

  rotmask_ctrl #(.OPC_ROTAND(OPC_ROTAND), .OPC_INSERT(OPC_INSERT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .outReady  (outReady),
    .opc       (fields.opc),
    .recBit    (fields.recBit),
    .inReady   (inReady),
    .outValid  (outValid),
    .illegalOp (illegalOp),
    .resWrite  (resWrite),
    .condWrite (condWrite),
    .strobe    (strobe)
  );

  rotmask_dp #(.XLEN(XLEN), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .shImm     (fields.rbSh[IDX_W-1:0]),
    .shReg     (shiftVal[IDX_W-1:0]),
    .maskBeg   (fields.maskBeg[IDX_W-1:0]),
    .maskEnd   (fields.maskEnd[IDX_W-1:0]),
    .srcLow    (srcVal[HALF_W-1:0]),
    .dstVal    (dstVal),
    .sumOvf    (sumOvf),
    .resultVal (resultVal),
    .condVal   (condVal)
  );
endmodule

// File: rtl/rotmask_chk.sv
module rotmask_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [XLEN-1:0] resultVal,
  input logic            resWrite,
  input logic            condWrite,
  input logic [3:0]      condVal,
  input logic            illegalOp
);
  a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid);

  a_r9_empty_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && !inValid |=> !outValid);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(resultVal) && $stable(condVal)
                              && $stable(illegalOp) && $stable(condWrite));

  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> outValid && !resWrite && !condWrite && resultVal == '0);

  a_r7_cond_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !condWrite |-> condVal == 4'b0000);

  a_r7_cond_sign: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && condWrite |-> $onehot(condVal[3:1]) && condVal[3] == resultVal[XLEN-1]
                              && condVal[1] == (resultVal == '0));
endmodule

bind rotmask_unit rotmask_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] instrWord = '0;
  logic [63:0] srcVal = '0;
  logic [63:0] dstVal = '0;
  logic [63:0] shiftVal = '0;
  logic        sumOvf = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] resultVal;
  logic        resWrite;
  logic        condWrite;
  logic [3:0]  condVal;
  logic        illegalOp;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  rotmask_unit u_rotmask_unit (.*);

  function automatic logic [31:0] mkInstr(int op, int sh, int mb, int me, int rc);
    return {6'(op), 5'd3, 5'd7, 5'(sh), 5'(mb), 5'(me), 1'(rc)};
  endfunction

  function automatic logic [31:0] refRot(logic [31:0] x, int n);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = x[(j - n + 32) % 32];
    return r;
  endfunction

  function automatic logic [63:0] refMask(int mb, int me);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      if (mb <= me) m[63-i] = (i >= mb + 32) && (i <= me + 32);
      else          m[63-i] = (i >= mb + 32) || (i <= me + 32);
    end
    return m;
  endfunction

  function automatic logic [3:0] refCond(logic [63:0] r, logic so);
    return {$signed(r) < 0, $signed(r) > 0, r == 64'd0, so};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] iw, logic [63:0] s, logic [63:0] d, logic [63:0] sh, logic so);
    @(negedge clk);
    instrWord = iw; srcVal = s; dstVal = d; shiftVal = sh; sumOvf = so;
    inValid = 1'b1; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 outValid", 64'(outValid), 64'd0);
    chk("R1 inReady", 64'(inReady), 64'd1);
    chk("R1 flags", {61'd0, illegalOp, resWrite, condWrite}, 64'd0);
  endtask

  task automatic tRotAnd();
    logic [63:0] src = 64'hDEAD_BEEF_1234_5678;
    issue(mkInstr(23, 0, 4, 20, 0), src, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFE5, 1'b0);
    chk("R2 R4 R11 rotand", resultVal, {2{refRot(src[31:0], 5)}} & refMask(4, 20));
    chk("R8 resWrite", 64'(resWrite), 64'd1);
    issue(mkInstr(23, 0, 31, 31, 0), 64'h0000_0000_8000_0001, 64'd0, 64'd1, 1'b0);
    chk("R4 single lsb", resultVal, 64'd1 & refMask(31, 31) & {2{refRot(32'h8000_0001, 1)}});
    issue(mkInstr(23, 0, 0, 0, 0), 64'h0000_0000_4000_0000, 64'd0, 64'd1, 1'b0);
    chk("R4 single msb of word", resultVal, 64'h0000_0000_8000_0000);
  endtask

  task automatic tPlainRot();
    issue(mkInstr(23, 0, 0, 31, 0), 64'h5555_AAAA_F000_000F, 64'd0, 64'd4, 1'b0);
    chk("R6 plain rotate", resultVal, 64'h0000_0000_0000_00FF);
    issue(mkInstr(23, 0, 0, 31, 0), 64'h0000_0000_89AB_CDEF, 64'd0, 64'd36, 1'b0);
    chk("R6 R11 count from low bits", resultVal, {32'd0, refRot(32'h89AB_CDEF, 4)});
  endtask

  task automatic tWrap();
    logic [31:0] r = refRot(32'h89AB_CDEF, 12);
    issue(mkInstr(23, 0, 28, 3, 1), 64'h0000_0000_89AB_CDEF, 64'd0, 64'd12, 1'b0);
    chk("R5 wrap mask", resultVal, {r, r} & refMask(28, 3));
    chk("R5 upper half kept", resultVal[63:32], 64'(r));
    chk("R7 cond wrap", 64'(condVal), 64'(refCond({r, r} & refMask(28, 3), 1'b0)));
  endtask

  task automatic tInsert();
    logic [63:0] d = 64'h0123_4567_89AB_CDEF;
    logic [63:0] m = refMask(8, 15);
    logic [31:0] r = refRot(32'h0000_00AB, 16);
    issue(mkInstr(20, 16, 8, 15, 0), 64'h0000_0000_0000_00AB, d, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    chk("R3 R11 insert", resultVal, ({r, r} & m) | (d & ~m));
    m = refMask(30, 1);
    r = refRot(32'hCAFE_F00D, 3);
    issue(mkInstr(20, 3, 30, 1, 0), 64'h0000_0000_CAFE_F00D, d, 64'd9, 1'b0);
    chk("R3 R5 insert wrap", resultVal, ({r, r} & m) | (d & ~m));
  endtask

  task automatic tCond();
    issue(mkInstr(23, 0, 0, 31, 1), 64'd0, 64'd0, 64'd0, 1'b1);
    chk("R7 zero", {59'd0, condWrite, condVal}, {59'd0, 1'b1, 4'b0011});
    issue(mkInstr(23, 0, 0, 31, 1), 64'h0000_0000_0000_0010, 64'd0, 64'd2, 1'b0);
    chk("R7 positive", {59'd0, condWrite, condVal}, {59'd0, 1'b1, 4'b0100});
    issue(mkInstr(20, 0, 0, 0, 1), 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
    chk("R7 negative insert", {59'd0, condWrite, condVal}, {59'd0, 1'b1, 4'b1001});
    issue(mkInstr(23, 0, 0, 31, 0), 64'h0000_0000_0000_0010, 64'd0, 64'd2, 1'b1);
    chk("R7 no record", {59'd0, condWrite, condVal}, 64'd0);
  endtask

  task automatic tIllegal();
    issue(mkInstr(21, 5, 0, 31, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'd1, 1'b1);
    chk("R8 illegal flags", {60'd0, outValid, illegalOp, resWrite, condWrite}, {60'd0, 4'b1100});
    chk("R8 illegal result", resultVal, 64'd0);
    @(negedge clk);
    chk("R8 one beat", {62'd0, outValid, illegalOp}, 64'd0);
  endtask

  task automatic tStall();
    logic [63:0] first = {32'd0, refRot(32'h1111_2222, 8)};
    logic [31:0] r2 = refRot(32'h0F0F_0F0F, 1);
    @(negedge clk);
    instrWord = mkInstr(23, 0, 0, 31, 1); srcVal = 64'h1111_2222; shiftVal = 64'd8;
    sumOvf = 1'b0; inValid = 1'b1; outReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 valid next cycle", {63'd0, outValid}, 64'd1);
    chk("R9 first result", resultVal, first);
    instrWord = mkInstr(23, 0, 16, 31, 0); srcVal = 64'h0F0F_0F0F; shiftVal = 64'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 hold result", resultVal, first);
      chk("R10 hold cond", {59'd0, condWrite, condVal}, {59'd0, 1'b1, 4'b0100});
      chk("R10 not ready", {63'd0, inReady}, 64'd0);
    end
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 back to back", resultVal, {r2, r2} & refMask(16, 31));
    chk("R9 still valid", {62'd0, outValid, condWrite}, 64'd2);
    @(negedge clk);
    chk("R9 drained", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    #(20 * 100000);
    failCnt++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tRotAnd();
    tPlainRot();
    tWrap();
    tInsert();
    tCond();
    tIllegal();
    tStall();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule